// File: doc/BRIEF.md
# UART Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a line that rests high. It does not generate a baud rate. Instead, a one-cycle enable arrives at twice the bit rate. The transmitter moves forward one half-bit on each enable, so every serial bit lasts two enables.

A start strobe latches the data byte and the whole line format when the transmitter is idle. The latched format covers the word length, the stop-bit choice and the parity mode. Any later change on those inputs cannot corrupt the frame in flight. A break input drives the line low while it is held. A clear strobe abandons the current frame. A finished pulse tells the surrounding logic when the next character can be loaded.

Top module: `uart_char_tx`

## Requirements
- R1: After reset and whenever idle with no break, `txd` is 1 and `done` is 0.
- R2: Each serial bit spans exactly two `half_tick` pulses. Without a pulse the line value does not change.
- R3: A frame is sent in this order: one start bit of 0, then the data bits least significant first, then a parity bit (only when `par_en` is 1), then the stop time at 1.
- R4: `word_sel` sets the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits above the word are not sent.
- R5: With `stop_sel` at 0 the stop time is two half-bits. With `stop_sel` at 1 it is three half-bits for a 5-bit word and four half-bits for longer words.
- R6: With parity enabled and stick parity off, the parity bit makes the count of ones in data plus parity even when `par_even` is 1, and odd when `par_even` is 0.
- R7: With parity enabled and `par_stick` at 1, the parity bit equals the inverse of `par_even`.
- R8: While `brk` is 1, `txd` is 0. Frame timing continues underneath, and the line returns to the frame's value when `brk` falls.
- R9: `done` is high for exactly one clock. It rises on the clock edge that consumes the final stop half-bit's `half_tick`.
- R10: `clear` returns the transmitter to idle at the next edge. `txd` is then 1 and no `done` pulse follows for the aborted frame.
- R11: Data and format are captured on the start edge. A `start` while busy is ignored, and input changes during a frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | One-clock enable at twice the baud rate |
| start | input | 1 | Begin a character (taken only when idle) |
| clear | input | 1 | Abort the character in progress |
| word_sel | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| stop_sel | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| par_en | input | 1 | Insert a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| par_stick | input | 1 | Force parity bit to the inverse of `par_even` |
| brk | input | 1 | Hold the line low |
| data | input | 8 | Character to send |
| txd | output | 1 | Serial line output |
| done | output | 1 | One-clock pulse when the frame completes |

## Verification
The assertions rely on three things in the stimulus:
- `half_tick` is a single-cycle pulse.
- The line can change only after a tick, a start, a clear or a change of `brk`.
- `clear` is never raised while `done` would fire.

The stimulus holds to all three. Ticks are always separated by at least one quiet clock, and clear strobes are placed mid-frame. Every combination of word length, stop select, parity enable, parity sense and stick parity is swept with two data patterns. During each frame the data and format inputs are scrambled and a second start is pulsed, to confirm that the latched copy governs the frame.

// File: rtl/uart_char_tx.sv
module uart_char_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       start,
  input  logic       clear,
  input  logic [1:0] word_sel,
  input  logic       stop_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       brk,
  input  logic [7:0] data,
  output logic       txd,
  output logic       done
);

  typedef enum logic [2:0] {IDLE, STRT, DBIT, PBIT, STOP} phase_t;

  phase_t     phase;
  logic [7:0] hold;
  logic [1:0] wsel;
  logic       ssel, pen, peven, pstick;
  logic       half;
  logic [2:0] idx;
  logic [1:0] stop_cnt;

  wire [2:0] last_idx  = {1'b1, wsel};
  wire [1:0] stop_last = !ssel ? 2'd1 : (wsel == 2'd0 ? 2'd2 : 2'd3);
  wire [7:0] mask      = 8'hFF >> (2'd3 - wsel);
  wire       ones      = ^(hold & mask);
  wire       pbit      = pstick ? ~peven : (peven ? ones : ~ones);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= IDLE;
      done     <= 1'b0;
      hold     <= 8'd0;
      wsel     <= 2'd3;
      ssel     <= 1'b0;
      pen      <= 1'b0;
      peven    <= 1'b0;
      pstick   <= 1'b0;
      half     <= 1'b0;
      idx      <= 3'd0;
      stop_cnt <= 2'd0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        phase <= IDLE;
      end else if (phase == IDLE) begin
        if (start) begin
          phase    <= STRT;
          hold     <= data;
          wsel     <= word_sel;
          ssel     <= stop_sel;
          pen      <= par_en;
          peven    <= par_even;
          pstick   <= par_stick;
          half     <= 1'b0;
          idx      <= 3'd0;
          stop_cnt <= 2'd0;
        end
      end else if (half_tick) begin
        half <= ~half;
        case (phase)
          STRT: if (half) phase <= DBIT;
          DBIT: if (half) begin
            idx <= idx + 3'd1;
            if (idx == last_idx) phase <= pen ? PBIT : STOP;
          end
          PBIT: if (half) phase <= STOP;
          STOP: begin
            if (stop_cnt == stop_last) begin
              phase <= IDLE;
              done  <= 1'b1;
            end else begin
              stop_cnt <= stop_cnt + 2'd1;
            end
          end
          default: phase <= IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (phase)
      STRT:    txd = 1'b0;
      DBIT:    txd = hold[idx];
      PBIT:    txd = pbit;
      default: txd = 1'b1;
    endcase
    if (brk) txd = 1'b0;
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(half_tick));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_tick && !start && !clear) |=> ($stable(brk) |-> $stable(txd)));

  // R10
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (phase == IDLE && !done));

  // R11
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != IDLE) |=> (phase == IDLE || ($stable(hold) && $stable(wsel) && $stable(pen))));

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == IDLE && !start) |=> (brk || txd));

endmodule

// File: tb/uart_char_tx_test.sv
module uart_char_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0, start = 1'b0, clear = 1'b0;
  logic [1:0] word_sel = 2'd3;
  logic stop_sel = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, brk = 1'b0;
  logic [7:0] data = 8'd0;
  logic txd, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic expv [0:31];
  int   hlen;

  always #5 clk = ~clk;

  uart_char_tx uut (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .start(start), .clear(clear),
    .word_sel(word_sel), .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .data(data), .txd(txd), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build(input logic [7:0] d, input logic [1:0] w, input logic s,
                       input logic p, input logic e, input logic k);
    int n;
    logic ones, pb;
    n = 5 + int'(w);
    hlen = 0;
    expv[hlen++] = 1'b0; expv[hlen++] = 1'b0;
    ones = 1'b0;
    for (int i = 0; i < n; i++) begin
      expv[hlen++] = d[i]; expv[hlen++] = d[i];
      ones = ones ^ d[i];
    end
    if (p) begin
      pb = k ? ~e : (e ? ones : ~ones);
      expv[hlen++] = pb; expv[hlen++] = pb;
    end
    for (int i = 0; i < (s ? (w == 2'd0 ? 3 : 4) : 2); i++) expv[hlen++] = 1'b1;
  endtask

  task automatic launch(input logic [7:0] d, input logic [1:0] w, input logic s,
                        input logic p, input logic e, input logic k);
    data = d; word_sel = w; stop_sel = s; par_en = p; par_even = e; par_stick = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    data = ~d; word_sel = ~w; stop_sel = ~s; par_en = ~p; par_even = ~e; par_stick = ~k;
  endtask

  task automatic frame(input logic [7:0] d, input logic [1:0] w, input logic s,
                       input logic p, input logic e, input logic k,
                       input int brk_lo, input int brk_hi);
    build(d, w, s, p, e, k);
    launch(d, w, s, p, e, k);
    for (int h = 0; h < hlen; h++) begin
      brk = (h >= brk_lo && h < brk_hi);
      #1;
      // R3 R4 R5 R6 R7 R8 R11
      chk(txd === (brk ? 1'b0 : expv[h]), "R3/R8 line half-bit", int'(txd), int'(brk ? 1'b0 : expv[h]));
      chk(done === 1'b0, "R9 no early done", int'(done), 0);
      half_tick = 1'b1;
      if (h == 3) start = 1'b1;
      @(negedge clk);
      half_tick = 1'b0; start = 1'b0;
      if (h != hlen - 1) begin
        // R2 held without tick
        chk(txd === (brk ? 1'b0 : expv[h+1]), "R2 line after tick", int'(txd), int'(brk ? 1'b0 : expv[h+1]));
        @(negedge clk);
      end
    end
    brk = 1'b0;
    #1;
    chk(done === 1'b1, "R9 done pulse", int'(done), 1);
    chk(txd === 1'b1, "R1 idle high after frame", int'(txd), 1);
    @(negedge clk);
    chk(done === 1'b0, "R9 done one cycle", int'(done), 0);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    chk(done === 1'b0, "R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 ticks while idle do nothing
    half_tick = 1'b1; @(negedge clk); half_tick = 1'b0; #1;
    chk(txd === 1'b1 && done === 1'b0, "R1 idle tick", int'(txd), 1);
    @(negedge clk);

    // R4 R5 R6 R7 sweep
    for (int cfg = 0; cfg < 32; cfg++) begin
      frame(8'hA5 ^ 8'(cfg * 37), cfg[1:0], cfg[2], cfg[3], cfg[4], 1'b0, 99, 99);
      frame(8'h3C + 8'(cfg * 11), cfg[1:0], cfg[2], cfg[3], cfg[4], 1'b1, 99, 99);
    end
    frame(8'hFF, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 99, 99);
    frame(8'h00, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 99, 99);

    // R8 break mid-frame
    frame(8'hFF, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4, 9);

    // R10 clear aborts
    launch(8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int h = 0; h < 5; h++) begin
      half_tick = 1'b1; @(negedge clk); half_tick = 1'b0; @(negedge clk);
    end
    clear = 1'b1; @(negedge clk); clear = 1'b0; #1;
    chk(txd === 1'b1, "R10 line high after clear", int'(txd), 1);
    for (int h = 0; h < 24; h++) begin
      half_tick = 1'b1; @(negedge clk); half_tick = 1'b0; #1;
      chk(done === 1'b0 && txd === 1'b1, "R10 no done after clear", int'(done), 0);
      @(negedge clk);
    end
    frame(8'h96, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 99, 99);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule